// File: doc/BRIEF.md
# USART Bit-Rate Tick Generator

This block sets the bit timing for a serial receiver and transmitter. A 2-bit source field chooses where the timing comes from: every system clock, a fixed prescaled fraction of the system clock, or rising edges on an external pin. A 16-bit divisor then divides that source. In asynchronous mode, a second stage divides the result by 16, or by 8 when the oversampling-select bit is set. Both results are single-cycle enables in the system clock domain, so the shifters that use them stay in that domain.

The divisor has two special values. Zero stops all ticks. One passes the source straight through with no division. The external pin goes through a two-flop synchroniser, and each rising edge becomes one source enable. Any change to a configuration input restarts both counters, so the next period begins cleanly.

Top module: `baud_clk_gen`

## Requirements
- R1: While `rst_n` is low, `sample_tick` and `baud_tick` are both low.
- R2: With `cd` equal to 0, neither tick is ever asserted, whatever the other inputs are.
- R3: With `cd` equal to 1, every source enable becomes a sample tick, so with `src_sel`=0 `sample_tick` is high on every cycle.
- R4: `src_sel` code 0 uses every system clock as a source enable, and code 1 uses one enable every `PRESC` clocks (default 8). Code 2 is reserved and produces no ticks.
- R5: `src_sel` code 3 takes one source enable per rising edge of `ext_clk`, after a two-flop synchroniser. Two enables never occur on adjacent cycles. `ext_clk` high and low phases of 5 clocks give a source period of 10 clocks.
- R6: In asynchronous mode (`sync_mode`=0), the `baud_tick` period equals source period × `cd` × 16 when `over8`=0, and source period × `cd` × 8 when `over8`=1.
- R7: In asynchronous mode, `sample_tick` repeats every `cd` source enables, and every `baud_tick` falls on a cycle that also carries `sample_tick`.
- R8: In synchronous mode (`sync_mode`=1), the oversampling stage is skipped. `baud_tick` and `sample_tick` then both repeat every source period × `cd`.
- R9: A change of any configuration input (`cd`, `over8`, `sync_mode`, `src_sel`) restarts both counters. With the internal source, the first `baud_tick` after the change comes exactly one full new period (P cycles) after the input changes, and no tick comes before it.
- R10: When the period is longer than one cycle, each `baud_tick` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Source code: 0 system clock, 1 prescaled, 2 reserved, 3 external pin |
| sync_mode | input | 1 | 1 skips the oversampling stage |
| over8 | input | 1 | Oversampling ratio: 1 gives 8, 0 gives 16 |
| cd | input | 16 | Divisor: 0 stops the block, 1 bypasses division |
| ext_clk | input | 1 | External timing pin, asynchronous |
| sample_tick | output | 1 | One-cycle enable at each sampling point |
| baud_tick | output | 1 | One-cycle enable at the end of each bit period |

## Verification
Both ticks are combinational from registered counter state, so each tick appears in the same cycle in which the counters reach their terminal values. The bench therefore drives inputs on the falling edge and samples on the next falling edge. Periods are measured as counts of edges between two consecutive ticks, once the first tick has been seen, so the prescaler phase and the synchroniser delay of two to three cycles do not affect the result. After a divisor change there is one cycle in which the change is detected and both ticks are suppressed. The counters start again from zero after the following edge, so the first tick is due exactly P edges after the change, and the bench counts it that way.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SRC_CORE  = 2'd0,
    SRC_PRESC = 2'd1,
    SRC_RSVD  = 2'd2,
    SRC_PIN   = 2'd3
  } src_sel_e;

  // last index of the oversampling counter for the chosen ratio
  function automatic logic [3:0] ovs_last(input logic over8);
    return over8 ? 4'd7 : 4'd15;
  endfunction

  // terminal count of the divider for a divisor value
  function automatic logic [15:0] div_last(input logic [15:0] cd);
    return cd - 16'd1;
  endfunction
endpackage

// File: rtl/src_select.sv
module src_select #(
  parameter int PRESC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       pin,
  output logic       src_en
);
  import baud_pkg::*;
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);

  logic [PW-1:0] pcnt;
  logic          presc_en;
  logic          s1, s2, s3;
  logic          pin_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= (pcnt == PLAST) ? '0 : pcnt + 1'b1;
  end
  assign presc_en = (pcnt == PLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else        {s1, s2, s3} <= {pin, s1, s2};
  end
  assign pin_rise = s2 & ~s3;

  always_comb begin
    case (src_sel_e'(sel))
      SRC_CORE:  src_en = 1'b1;
      SRC_PRESC: src_en = presc_en;
      SRC_PIN:   src_en = pin_rise;
      default:   src_en = 1'b0;
    endcase
  end

  // R5
  pin_rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
  // R4
  rsvd_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd2) |-> !src_en);
endmodule

// File: rtl/cd_divider.sv
module cd_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cd,
  input  logic         src_en,
  input  logic         restart,
  output logic         div_en
);
  import baud_pkg::*;
  logic [W-1:0] cnt;
  logic         active, bypass, hit;

  assign active = (cd != '0);
  assign bypass = (cd == W'(1));
  assign hit    = active && src_en && (bypass || cnt == W'(div_last(16'(cd))));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !active) cnt <= '0;
    else if (src_en)                  cnt <= hit ? '0 : cnt + 1'b1;
  end
  assign div_en = hit && !restart;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart) |-> (cnt < cd));
endmodule

// File: rtl/ovs_stage.sv
module ovs_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic div_en,
  input  logic sync_mode,
  input  logic over8,
  input  logic restart,
  output logic sample_tick,
  output logic baud_tick
);
  import baud_pkg::*;
  logic [3:0] ocnt;
  logic [3:0] last;
  logic       wrap;

  assign last = ovs_last(over8);
  assign wrap = div_en && (ocnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || sync_mode) ocnt <= '0;
    else if (div_en)                    ocnt <= wrap ? '0 : ocnt + 1'b1;
  end

  assign sample_tick = div_en;
  assign baud_tick   = sync_mode ? div_en : wrap;

  // R7
  ocnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !restart) |-> (ocnt <= last));
  // R7
  baud_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> sample_tick);
  // R10
  baud_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !sync_mode && !restart) |=> !baud_tick);
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen #(
  parameter int CD_W  = 16,
  parameter int PRESC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      src_sel,
  input  logic            sync_mode,
  input  logic            over8,
  input  logic [CD_W-1:0] cd,
  input  logic            ext_clk,
  output logic            sample_tick,
  output logic            baud_tick
);
  localparam int CFG_W = CD_W + 4;

  logic [CFG_W-1:0] cfg, cfg_q;
  logic             cfg_chg, restart;
  logic             src_en, div_en;

  assign cfg = {src_sel, sync_mode, over8, cd};
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;
  end
  assign cfg_chg = (cfg != cfg_q);
  assign restart = cfg_chg || !rst_n;

  src_select #(.PRESC(PRESC)) u_src (
    .clk(clk), .rst_n(rst_n), .sel(src_sel), .pin(ext_clk), .src_en(src_en)
  );

  cd_divider #(.W(CD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .cd(cd), .src_en(src_en),
    .restart(restart), .div_en(div_en)
  );

  ovs_stage u_ovs (
    .clk(clk), .rst_n(rst_n), .div_en(div_en), .sync_mode(sync_mode),
    .over8(over8), .restart(restart),
    .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!sample_tick && !baud_tick));
  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cd == '0) |-> (!sample_tick && !baud_tick));
  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |-> (!sample_tick && !baud_tick));
endmodule

// File: tb/sim_baud_clk_gen.sv
module sim_baud_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic        sync_mode = 1'b0;
  logic        over8 = 1'b0;
  logic [15:0] cd = 16'd1;
  logic        ext_clk = 1'b0;
  logic        sample_tick, baud_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_clk_gen u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sync_mode(sync_mode),
    .over8(over8), .cd(cd), .ext_clk(ext_clk),
    .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  // external pin: 5 clocks high, 5 low
  initial forever begin
    repeat (5) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  typedef struct packed {
    logic [1:0]  src;
    logic        sync;
    logic        ovr;
    logic [15:0] cdv;
    logic [15:0] baud_p;
    logic [15:0] samp_p;
  } vec_t;

  // periods restated per requirement: src_period * cd * (sync ? 1 : (ovr ? 8 : 16))
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b1, 16'd1, 16'd8,   16'd1 },
    '{2'd0, 1'b0, 1'b0, 16'd1, 16'd16,  16'd1 },
    '{2'd0, 1'b0, 1'b1, 16'd3, 16'd24,  16'd3 },
    '{2'd0, 1'b0, 1'b0, 16'd5, 16'd80,  16'd5 },
    '{2'd0, 1'b1, 1'b0, 16'd4, 16'd4,   16'd4 },
    '{2'd1, 1'b0, 1'b1, 16'd1, 16'd64,  16'd8 },
    '{2'd1, 1'b0, 1'b0, 16'd2, 16'd256, 16'd16},
    '{2'd1, 1'b1, 1'b0, 16'd3, 16'd24,  16'd24},
    '{2'd3, 1'b0, 1'b1, 16'd2, 16'd160, 16'd20},
    '{2'd3, 1'b1, 1'b0, 16'd1, 16'd10,  16'd10}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input bit which);
    return which ? baud_tick : sample_tick;
  endfunction

  // cycles between two consecutive ticks; -1 if none seen
  task automatic measure(input bit which, output int per);
    int c;
    bit seen;
    per = -1;
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); @(negedge clk);
      if (pick(which)) begin seen = 1'b1; break; end
    end
    if (!seen) return;
    c = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); @(negedge clk);
      c++;
      if (pick(which)) begin per = c; break; end
    end
  endtask

  task automatic setup(input logic [1:0] s, input logic sy, input logic ov,
                       input logic [15:0] d);
    @(negedge clk);
    rst_n = 1'b0;
    src_sel = s; sync_mode = sy; over8 = ov; cd = d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (sample_tick || baud_tick) cnt++;
    end
  endtask

  // first baud tick after a divisor change, counted in edges
  task automatic change_latency(input logic [15:0] newcd, output int k);
    k = -1;
    @(negedge clk);
    cd = newcd;
    for (int i = 1; i <= 2000; i++) begin
      @(posedge clk); @(negedge clk);
      if (baud_tick) begin k = i; break; end
    end
  endtask

  initial begin
    int per, n, k;
    // R1: reset state
    src_sel = 2'd0; cd = 16'd1; over8 = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 sample_tick in reset", int'(sample_tick), 0);
    check("R1 baud_tick in reset", int'(baud_tick), 0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v].src, VEC[v].sync, VEC[v].ovr, VEC[v].cdv);
      measure(1'b1, per);
      check($sformatf("R6/R8/R4/R5 baud period vec%0d", v), per, int'(VEC[v].baud_p));
      measure(1'b0, per);
      check($sformatf("R7/R3 sample period vec%0d", v), per, int'(VEC[v].samp_p));
    end

    // R2: divisor zero stops everything
    setup(2'd0, 1'b0, 1'b1, 16'd0);
    count_ticks(300, n);
    check("R2 ticks with cd=0", n, 0);
    // R4: reserved source code 2
    setup(2'd2, 1'b0, 1'b1, 16'd1);
    count_ticks(300, n);
    check("R4 ticks with reserved source", n, 0);

    // R10: one-cycle baud tick
    setup(2'd0, 1'b0, 1'b1, 16'd3);
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); @(negedge clk);
      if (baud_tick) break;
    end
    @(posedge clk); @(negedge clk);
    check("R10 baud_tick cycle after tick", int'(baud_tick), 0);

    // R9: restart on divisor change
    setup(2'd0, 1'b0, 1'b1, 16'd2);
    repeat (11) @(negedge clk);
    change_latency(16'd4, k);
    check("R9 first tick after cd 2->4", k, 32);
    repeat (5) @(negedge clk);
    change_latency(16'd1, k);
    check("R9 first tick after cd 4->1", k, 8);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule